// File: doc/BRIEF.md
# Multi-LFSR Active Test Set Monitor

This block is the front end of an input-monitoring concurrent self-test scheme. The circuit under test keeps running on its normal input vectors while the block watches the same vectors. It holds several independent linear feedback shift registers, called lanes. The present state of each lane is one active test vector, so the whole set of lane states is the active test set. Each valid input vector is compared against every lane at once.

A lane whose state equals the incoming vector has a hit. That lane, and only that lane, steps to its next state. A response-capture enable is then pulsed for the downstream signature register. A parameter chooses between one enable per lane, for verifiers that depend on hit order, and a single shared enable, for a verifier that does not. A lane is finished once it has stepped back to its seed. When every lane is finished, the block raises a completion flag. With one lane the block becomes a plain single-comparator monitor. The signature registers and the circuit under test are outside this block.

Top module: `ats_monitor`

## Requirements
- R1: A synchronous active-high reset clears every enable output and `done_o`. It also loads lane i (counting from 0) with the seed value i+1.
- R2: While `vld_i` is low, no enable is raised and no lane state changes, whatever `vec_i` carries.
- R3: When `vld_i` is high and `vec_i` equals the state of an unfinished lane, that lane steps once to its next state. For a 4-bit vector, the next state is the state shifted right by one, XORed with 4'hC when the bit that left was 1. The lane's enable is high in exactly the following cycle.
- R4: A lane whose state differs from `vec_i` holds its state and raises no enable in that cycle.
- R5: With separate enables (SHARED_EN=0), bit i of `rve_o` belongs only to lane i.
- R6: With a shared enable (SHARED_EN=1), `rve_o` is one bit. It is high in the cycle after any lane hits.
- R7: A lane is finished once a step returns it to its seed, so each lane takes 2^VEC_W-1 hits. A finished lane produces no further hits. After `done_o` is high, no enable is raised.
- R8: `done_o` rises in the same cycle as the enable of the last lane's final hit. It stays high until reset.
- R9: With NUM_LFSR=1, the single lane steps and pulses its enable on each match of its one active vector.
- R10: A reset in the middle of a run returns every lane to its seed and clears all finished marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Input vector valid strobe |
| vec_i | input | VEC_W | Normal input vector applied to the circuit under test |
| rve_o | output | SHARED_EN ? 1 : NUM_LFSR | Registered response-capture enable(s) |
| done_o | output | 1 | Registered flag: all lanes have finished their sequences |

## Verification
The hardest situation to reach from the ports is completion. Every lane must be driven through its entire sequence, and each step demands the one vector equal to that lane's current state. The bench therefore sweeps every 4-bit value repeatedly, with gaps in the valid strobe, until all lanes in three instances have finished. It then keeps sweeping to confirm that nothing more happens. A bench-side arithmetic model of each lane predicts every enable and the exact cycle in which `done_o` rises. A reset in the middle of the run, followed by the seed vectors, shows that the lanes restart.

// File: rtl/ats_pkg.sv
package ats_pkg;

  // Galois right-shift feedback masks giving maximal-length sequences
  function automatic logic [31:0] galois_mask(input int width);
    logic [31:0] m;
    case (width)
      2:  m = 32'h3;
      3:  m = 32'h6;
      4:  m = 32'hC;
      5:  m = 32'h14;
      6:  m = 32'h30;
      7:  m = 32'h60;
      8:  m = 32'hB8;
      9:  m = 32'h110;
      10: m = 32'h240;
      11: m = 32'h500;
      12: m = 32'hE08;
      13: m = 32'h1C80;
      14: m = 32'h3802;
      15: m = 32'h6000;
      16: m = 32'hD008;
      default: m = 32'h0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ats_lfsr_lane.sv
module ats_lfsr_lane #(
  parameter int VEC_W = 4,
  parameter int SEED  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [VEC_W-1:0] vec,
  output logic             hit,
  output logic             fin_nxt
);
  import ats_pkg::*;

  localparam logic [31:0]      MASK32 = galois_mask(VEC_W);
  localparam logic [VEC_W-1:0] MASK   = MASK32[VEC_W-1:0];
  localparam logic [31:0]      SEED32 = SEED;
  localparam logic [VEC_W-1:0] SEED_V = SEED32[VEC_W-1:0];

  logic [VEC_W-1:0] state_q;
  logic [VEC_W-1:0] step_v;
  logic             fin_q;

  always_comb begin
    step_v = {1'b0, state_q[VEC_W-1:1]} ^ (state_q[0] ? MASK : '0);
    hit    = vld && !fin_q && (vec == state_q);
    fin_nxt = fin_q || (hit && (step_v == SEED_V));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED_V;
      fin_q   <= 1'b0;
    end else begin
      if (hit) state_q <= step_v;
      fin_q <= fin_nxt;
    end
  end

  assert_step_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state_q != $past(state_q)));

  assert_hold_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(state_q));

  assert_fin_at_seed_R7: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> (state_q == SEED_V));

  assert_fin_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> fin_q);

  assert_no_hit_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !vld |-> !hit);

endmodule

// File: rtl/ats_rve_merge.sv
module ats_rve_merge #(
  parameter int NUM_LFSR  = 2,
  parameter bit SHARED_EN = 1'b0,
  parameter int EN_W      = SHARED_EN ? 1 : NUM_LFSR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LFSR-1:0] hit,
  output logic [EN_W-1:0]     rve_o
);

  logic [EN_W-1:0] rve_d;

  generate
    if (SHARED_EN) begin : g_shared
      always_comb rve_d = EN_W'(|hit);
    end else begin : g_split
      always_comb rve_d = EN_W'(hit);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rve_o <= '0;
    else     rve_o <= rve_d;
  end

  generate
    if (SHARED_EN) begin : g_chk_shared
      assert_shared_from_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> rve_o[0]);
    end else begin : g_chk_split
      assert_split_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit) |=> $onehot0(rve_o));
    end
  endgenerate

endmodule

// File: rtl/ats_done_track.sv
module ats_done_track #(
  parameter int NUM_LFSR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LFSR-1:0] fin_nxt,
  output logic                done_o
);

  always_ff @(posedge clk) begin
    if (rst) done_o <= 1'b0;
    else     done_o <= &fin_nxt;
  end

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

endmodule

// File: rtl/ats_monitor.sv
module ats_monitor #(
  parameter int VEC_W     = 4,
  parameter int NUM_LFSR  = 2,
  parameter bit SHARED_EN = 1'b0,
  parameter int EN_W      = SHARED_EN ? 1 : NUM_LFSR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [EN_W-1:0]  rve_o,
  output logic             done_o
);

  logic [NUM_LFSR-1:0] lane_hit;
  logic [NUM_LFSR-1:0] lane_fin_nxt;

  generate
    for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lane
      ats_lfsr_lane #(
        .VEC_W (VEC_W),
        .SEED  (i + 1)
      ) u_lane (
        .clk     (clk),
        .rst     (rst),
        .vld     (vld_i),
        .vec     (vec_i),
        .hit     (lane_hit[i]),
        .fin_nxt (lane_fin_nxt[i])
      );
    end
  endgenerate

  ats_rve_merge #(
    .NUM_LFSR  (NUM_LFSR),
    .SHARED_EN (SHARED_EN),
    .EN_W      (EN_W)
  ) u_merge (
    .clk   (clk),
    .rst   (rst),
    .hit   (lane_hit),
    .rve_o (rve_o)
  );

  ats_done_track #(
    .NUM_LFSR (NUM_LFSR)
  ) u_done (
    .clk     (clk),
    .rst     (rst),
    .fin_nxt (lane_fin_nxt),
    .done_o  (done_o)
  );

  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (rve_o == '0));

endmodule

// File: tb/sim_ats_monitor.sv
module sim_ats_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [3:0] vec = 4'h0;
  logic [2:0] rve_a;
  logic [0:0] rve_b, rve_c;
  logic done_a, done_b, done_c;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ats_monitor #(.VEC_W(4), .NUM_LFSR(3), .SHARED_EN(1'b0)) u0 (
    .clk(clk), .rst(rst), .vld_i(vld), .vec_i(vec), .rve_o(rve_a), .done_o(done_a));
  ats_monitor #(.VEC_W(4), .NUM_LFSR(2), .SHARED_EN(1'b1)) u1 (
    .clk(clk), .rst(rst), .vld_i(vld), .vec_i(vec), .rve_o(rve_b), .done_o(done_b));
  ats_monitor #(.VEC_W(4), .NUM_LFSR(1), .SHARED_EN(1'b0)) u2 (
    .clk(clk), .rst(rst), .vld_i(vld), .vec_i(vec), .rve_o(rve_c), .done_o(done_c));

  logic [3:0] ma [3];
  logic [2:0] fa;
  logic [3:0] mb [2];
  logic [1:0] fb;
  logic [3:0] mc;
  logic       fc;

  function automatic logic [3:0] nxt(input logic [3:0] s);
    return {1'b0, s[3:1]} ^ (s[0] ? 4'hC : 4'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) ma[i] = 4'(i + 1);
    for (int i = 0; i < 2; i++) mb[i] = 4'(i + 1);
    mc = 4'h1; fa = '0; fb = '0; fc = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vld = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(rve_a == 3'b0 && done_a == 1'b0, "R1 reset u0", {rve_a, done_a}, 0);
    chk(rve_b == 1'b0 && done_b == 1'b0, "R1 reset u1", {rve_b, done_b}, 0);
    chk(rve_c == 1'b0 && done_c == 1'b0, "R1 reset u2", {rve_c, done_c}, 0);
  endtask

  // Drive one cycle at a negedge, predict, sample at the next negedge
  task automatic cyc(input logic v, input logic [3:0] x, input string tag);
    logic [2:0] ea;
    logic [1:0] eb;
    logic       ec;
    vld = v; vec = x;
    for (int i = 0; i < 3; i++) begin
      ea[i] = v && !fa[i] && (x == ma[i]);
      if (ea[i]) begin ma[i] = nxt(ma[i]); if (ma[i] == 4'(i + 1)) fa[i] = 1'b1; end
    end
    for (int i = 0; i < 2; i++) begin
      eb[i] = v && !fb[i] && (x == mb[i]);
      if (eb[i]) begin mb[i] = nxt(mb[i]); if (mb[i] == 4'(i + 1)) fb[i] = 1'b1; end
    end
    ec = v && !fc && (x == mc);
    if (ec) begin mc = nxt(mc); if (mc == 4'h1) fc = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    chk(rve_a == ea, {tag, " R5 u0 enables"}, rve_a, ea);
    chk(rve_b[0] == (|eb), {tag, " R6 u1 shared enable"}, rve_b, |eb);
    chk(rve_c[0] == ec, {tag, " R9 u2 single lane"}, rve_c, ec);
    chk(done_a == (&fa) && done_b == (&fb) && done_c == fc, {tag, " R8 done"},
        {done_a, done_b, done_c}, {&fa, &fb, fc});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R2: strobe low with seed vectors
    cyc(1'b0, 4'h1, "R2 idle");
    cyc(1'b0, 4'h2, "R2 idle");
    // R1/R3: seed 1 matches lane 0 of every instance
    cyc(1'b1, 4'h1, "R1 R3 seed1");
    // R4: lane 1 still holds seed 2, lane 0 now at C
    cyc(1'b1, 4'h2, "R4 seed2");
    cyc(1'b1, 4'h3, "R1 seed3");
    cyc(1'b1, 4'h0, "R4 zero never matches");
    cyc(1'b1, 4'hC, "R3 lane0 second step");
    // R10: mid-run reset restarts from seeds
    do_reset();
    cyc(1'b1, 4'h1, "R10 restart lane0");
    cyc(1'b1, 4'h2, "R10 restart lane1");
    // R7/R8: sweep until every lane everywhere has finished
    for (int s = 0; s < 60; s++) begin
      for (int v = 0; v < 16; v++)
        cyc(!((s % 3) == 1 && v[0]), 4'(v), "R7 sweep");
      if ((&fa) && (&fb) && fc) break;
    end
    chk((&fa) && (&fb) && fc, "R8 all lanes reach completion", {fa, fb, fc}, 6'h3F);
    // R7: nothing more after completion
    for (int v = 0; v < 16; v++) cyc(1'b1, 4'(v), "R7 after done");
    do_reset();
    cyc(1'b1, 4'h3, "R10 after done reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule